// File: doc/BRIEF.md
# Serial Port Mode and Status Register

This block is the 8-bit control and status register of a serial port that runs either as an SPI port or as a UART. It sits between a simple CPU register bus and the serial engine. On the bus side it decodes one register address for reads and writes. It also sees the strobes that the CPU issues when it reads or writes the separate data buffer. On the engine side it takes one-cycle event pulses for a framing error, a parity error, a received byte and a transmitted byte. It also takes a busy level and the level of the SPI slave-select input.

The upper three bits are configuration: port mode, receiver enable and SPI role. They drive registered outputs towards the engine. Bits 4 down to 1 are sticky status flags. Only engine events set them. The CPU can only clear them: by writing 0 to them, by reading the register (error flags), or by a data-buffer access (byte flags). Bit 0 is a live activity indicator. When the CPU clears the received-byte flag by hand, the block emits a one-cycle discard pulse so that the buffered byte is dropped.

A register read is captured into a registered read-data port one cycle after the read strobe. The captured value is the register as it stood before any clear caused by that read.

Top module: `sercfg_csr`

## Requirements
- R1: Bits 7 (port mode, 1 = UART, 0 = SPI), 6 (receiver enable) and 5 (SPI role, 1 = slave, 0 = master) take the written data on a register write. They appear on the configuration outputs one cycle after the write and read back in the same positions.
- R2: In UART mode a framing-error event sets bit 4 and a parity-error event sets bit 3; these events are ignored in SPI mode. A register read returns both bits as they were before the read and clears them on that clock edge.
- R3: Writing 0 to any of bits 4..1 clears that flag. Writing 1 leaves it unchanged, so a flag is never set by the CPU.
- R4: A received-byte event sets bit 2 in UART mode or in SPI slave mode and is ignored in SPI master mode. A data-buffer read clears bit 2.
- R5: A transmitted-byte event sets bit 1 in UART mode or in SPI master mode and is ignored in SPI slave mode. A data-buffer write clears bit 1.
- R6: A register write with bit 2 at 0 while the received-byte flag is set produces a one-cycle discard pulse in the cycle after the write. No other condition produces the pulse.
- R7: Bit 0 is read-only. In SPI slave mode it returns the slave-select level; in every other mode it returns the engine busy level. The value is sampled at the read strobe.
- R8: When an engine set event and a CPU clear of the same flag fall in the same cycle, the flag ends set.
- R9: Synchronous reset clears all register bits, the discard pulse and the read-data port. Read data changes only on a read strobe addressed to this register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | CPU register address |
| bus_rd | input | 1 | CPU register read strobe |
| bus_wr | input | 1 | CPU register write strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read hit |
| buf_rd | input | 1 | CPU data-buffer read strobe |
| buf_wr | input | 1 | CPU data-buffer write strobe |
| ev_frame_err | input | 1 | Engine pulse: stop bit had the wrong level |
| ev_parity_err | input | 1 | Engine pulse: parity mismatch |
| ev_rx_byte | input | 1 | Engine pulse: byte received |
| ev_tx_byte | input | 1 | Engine pulse: last written byte fully sent |
| eng_busy | input | 1 | Engine transmit or receive activity level |
| ss_level | input | 1 | SPI slave-select input level |
| cfg_uart | output | 1 | Port mode, 1 = UART |
| cfg_rx_en | output | 1 | UART receiver enable |
| cfg_slave | output | 1 | SPI role, 1 = slave |
| rx_discard | output | 1 | One-cycle pulse: drop the buffered received byte |

## Verification
The bench builds the block with its default 8-bit address and the register placed at address 0x10. Part of the random traffic goes to other addresses, which shows that only an exact address match reads, writes or clears. Random writes move the port through all mode and role combinations while events and clears collide. This brings the gating in each mode, the priority of set over clear and the read-before-clear ordering within reach on the same flags.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int REG_W     = 8;
  localparam int NFLAG     = 4;
  localparam int POS_ACT   = 0;
  localparam int POS_FLAG0 = 1;
  localparam int POS_SLAVE = 5;
  localparam int POS_RXEN  = 6;
  localparam int POS_MODE  = 7;
  localparam int NCFG      = 3;

  // flag index: 0 = tx done (bit1), 1 = rx ready (bit2), 2 = parity (bit3), 3 = frame (bit4)
  localparam int F_TX  = 0;
  localparam int F_RX  = 1;
  localparam int F_PAR = 2;
  localparam int F_FRM = 3;

  localparam logic [NFLAG-1:0] CLR_ON_CSR_RD = 4'b1100;
  localparam logic [NFLAG-1:0] CLR_ON_BUF_RD = 4'b0010;
  localparam logic [NFLAG-1:0] CLR_ON_BUF_WR = 4'b0001;

  typedef struct packed {
    logic uart;
    logic rx_en;
    logic slave;
  } cfg_t;
endpackage

// File: rtl/sercfg_flag.sv
module sercfg_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    set |=> q);
  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (!set && clr) |=> !q);
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!set && !clr) |=> $stable(q));
endmodule

// File: rtl/sercfg_cfg_reg.sv
module sercfg_cfg_reg
  import sercfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_hit,
  input  logic [NCFG-1:0] wr_bits,
  output cfg_t            cfg
);
  always_ff @(posedge clk) begin
    if (rst)         cfg <= '0;
    else if (wr_hit) cfg <= cfg_t'(wr_bits);
  end

  assert_cfg_write_R1: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (cfg == cfg_t'($past(wr_bits))));
  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(cfg));
endmodule

// File: rtl/sercfg_readback.sv
module sercfg_readback
  import sercfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_hit,
  input  cfg_t             cfg,
  input  logic [NFLAG-1:0] flags,
  input  logic             eng_busy,
  input  logic             ss_level,
  input  logic             discard_req,
  output logic [REG_W-1:0] rdata,
  output logic             discard
);
  logic act;
  logic spi_slave;

  assign spi_slave = !cfg.uart && cfg.slave;
  assign act       = spi_slave ? ss_level : eng_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      discard <= 1'b0;
    end else begin
      discard <= discard_req;
      if (rd_hit) begin
        rdata[POS_MODE]  <= cfg.uart;
        rdata[POS_RXEN]  <= cfg.rx_en;
        rdata[POS_SLAVE] <= cfg.slave;
        rdata[POS_FLAG0 +: NFLAG] <= flags;
        rdata[POS_ACT]   <= act;
      end
    end
  end

  assert_active_ss_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !cfg.uart && cfg.slave) |=> (rdata[POS_ACT] == $past(ss_level)));
  assert_active_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && (cfg.uart || !cfg.slave)) |=> (rdata[POS_ACT] == $past(eng_busy)));
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> $stable(rdata));
endmodule

// File: rtl/sercfg_csr.sv
module sercfg_csr
  import sercfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              buf_rd,
  input  logic              buf_wr,
  input  logic              ev_frame_err,
  input  logic              ev_parity_err,
  input  logic              ev_rx_byte,
  input  logic              ev_tx_byte,
  input  logic              eng_busy,
  input  logic              ss_level,
  output logic              cfg_uart,
  output logic              cfg_rx_en,
  output logic              cfg_slave,
  output logic              rx_discard
);
  logic             wr_hit;
  logic             rd_hit;
  cfg_t             cfg;
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;
  logic [NFLAG-1:0] ev_vec;
  logic [NFLAG-1:0] gate;
  logic             discard_req;
  logic             unused_wbit;

  assign wr_hit      = bus_wr && (bus_addr == CSR_ADDR);
  assign rd_hit      = bus_rd && (bus_addr == CSR_ADDR);
  assign unused_wbit = bus_wdata[POS_ACT];

  sercfg_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_hit  (wr_hit),
    .wr_bits (bus_wdata[POS_SLAVE +: NCFG]),
    .cfg     (cfg)
  );

  assign ev_vec[F_TX]  = ev_tx_byte;
  assign ev_vec[F_RX]  = ev_rx_byte;
  assign ev_vec[F_PAR] = ev_parity_err;
  assign ev_vec[F_FRM] = ev_frame_err;

  assign gate[F_TX]  = cfg.uart || !cfg.slave;
  assign gate[F_RX]  = cfg.uart || cfg.slave;
  assign gate[F_PAR] = cfg.uart;
  assign gate[F_FRM] = cfg.uart;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign flag_set[i] = ev_vec[i] && gate[i];
    assign flag_clr[i] = (wr_hit && !bus_wdata[POS_FLAG0 + i])
                       || (rd_hit && CLR_ON_CSR_RD[i])
                       || (buf_rd && CLR_ON_BUF_RD[i])
                       || (buf_wr && CLR_ON_BUF_WR[i]);
    sercfg_flag u_flag (
      .clk (clk),
      .rst (rst),
      .set (flag_set[i]),
      .clr (flag_clr[i]),
      .q   (flag_q[i])
    );
  end

  assign discard_req = wr_hit && !bus_wdata[POS_FLAG0 + F_RX] && flag_q[F_RX];

  sercfg_readback u_rb (
    .clk         (clk),
    .rst         (rst),
    .rd_hit      (rd_hit),
    .cfg         (cfg),
    .flags       (flag_q),
    .eng_busy    (eng_busy),
    .ss_level    (ss_level),
    .discard_req (discard_req),
    .rdata       (bus_rdata),
    .discard     (rx_discard)
  );

  assign cfg_uart  = cfg.uart;
  assign cfg_rx_en = cfg.rx_en;
  assign cfg_slave = cfg.slave;

  assert_discard_cause_R6: assert property (@(posedge clk) disable iff (rst)
    rx_discard |-> $past(wr_hit && !bus_wdata[POS_FLAG0 + F_RX] && flag_q[F_RX]));
  assert_err_read_R2: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (bus_rdata[POS_FLAG0 + F_FRM -: 2] == $past(flag_q[F_FRM -: 2])));
  assert_master_no_rx_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg.uart && !cfg.slave && !flag_q[F_RX]) |=> !flag_q[F_RX]);
  assert_slave_no_tx_R5: assert property (@(posedge clk) disable iff (rst)
    (!cfg.uart && cfg.slave && !flag_q[F_TX]) |=> !flag_q[F_TX]);
  assert_spi_no_err_R2: assert property (@(posedge clk) disable iff (rst)
    (!cfg.uart && !flag_q[F_FRM]) |=> !flag_q[F_FRM]);
endmodule

// File: tb/test_sercfg_csr.sv
module test_sercfg_csr;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CSR = 8'h10;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic buf_rd = 0, buf_wr = 0;
  logic ev_frame_err = 0, ev_parity_err = 0, ev_rx_byte = 0, ev_tx_byte = 0;
  logic eng_busy = 0, ss_level = 0;
  logic cfg_uart, cfg_rx_en, cfg_slave, rx_discard;

  int n_cmp = 0;
  int n_bad = 0;
  int n_cyc = 0;

  logic [2:0] e_cfg = '0;
  logic [3:0] e_st  = '0;
  logic [7:0] e_rd  = '0;
  logic       e_disc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sercfg_csr #(.ADDR_W(8), .CSR_ADDR(CSR)) i_sercfg_csr (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .buf_rd(buf_rd), .buf_wr(buf_wr),
    .ev_frame_err(ev_frame_err), .ev_parity_err(ev_parity_err),
    .ev_rx_byte(ev_rx_byte), .ev_tx_byte(ev_tx_byte), .eng_busy(eng_busy),
    .ss_level(ss_level), .cfg_uart(cfg_uart), .cfg_rx_en(cfg_rx_en),
    .cfg_slave(cfg_slave), .rx_discard(rx_discard)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h (cycle %0d)", tag, got, exp, n_cyc);
    end
  endtask

  function automatic logic act_bit(logic [2:0] c, logic busy, logic ss);
    return (!c[2] && c[0]) ? ss : busy;
  endfunction

  task automatic model_step();
    logic hw, hr;
    logic [3:0] sv, cv;
    if (rst) begin
      e_cfg = '0; e_st = '0; e_rd = '0; e_disc = 1'b0;
      return;
    end
    hw = bus_wr && (bus_addr == CSR);
    hr = bus_rd && (bus_addr == CSR);
    sv[0] = ev_tx_byte    && (e_cfg[2] || !e_cfg[0]);
    sv[1] = ev_rx_byte    && (e_cfg[2] ||  e_cfg[0]);
    sv[2] = ev_parity_err &&  e_cfg[2];
    sv[3] = ev_frame_err  &&  e_cfg[2];
    cv[0] = (hw && !bus_wdata[1]) || buf_wr;
    cv[1] = (hw && !bus_wdata[2]) || buf_rd;
    cv[2] = (hw && !bus_wdata[3]) || hr;
    cv[3] = (hw && !bus_wdata[4]) || hr;
    if (hr) e_rd = {e_cfg, e_st, act_bit(e_cfg, eng_busy, ss_level)};
    e_disc = hw && !bus_wdata[2] && e_st[1];
    e_st = sv | (e_st & ~cv);
    if (hw) e_cfg = bus_wdata[7:5];
  endtask

  task automatic check_all();
    chk("R1 cfg outputs", {5'b0, cfg_uart, cfg_rx_en, cfg_slave}, {5'b0, e_cfg});
    chk("R6 discard", {7'b0, rx_discard}, {7'b0, e_disc});
    chk("R1 rdata cfg", {5'b0, bus_rdata[7:5]}, {5'b0, e_rd[7:5]});
    chk("R2 rdata errors", {6'b0, bus_rdata[4:3]}, {6'b0, e_rd[4:3]});
    chk("R4 rdata rx flag", {7'b0, bus_rdata[2]}, {7'b0, e_rd[2]});
    chk("R5 rdata tx flag", {7'b0, bus_rdata[1]}, {7'b0, e_rd[1]});
    chk("R7 rdata active", {7'b0, bus_rdata[0]}, {7'b0, e_rd[0]});
  endtask

  task automatic idle();
    bus_rd = 0; bus_wr = 0; buf_rd = 0; buf_wr = 0; bus_addr = CSR;
    ev_frame_err = 0; ev_parity_err = 0; ev_rx_byte = 0; ev_tx_byte = 0;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
    n_cyc++;
    check_all();
    idle();
  endtask

  task automatic csr_wr(logic [7:0] d);
    bus_wr = 1; bus_wdata = d; tick();
  endtask

  task automatic csr_rd();
    bus_rd = 1; tick();
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    rst = 1;
    repeat (3) tick();
    rst = 0;
    // R9: reset state
    chk("R9 reset rdata", bus_rdata, 8'h00);
    chk("R9 reset discard", {7'b0, rx_discard}, 8'h00);
    csr_rd();
    chk("R9 reset read", bus_rdata, 8'h00);

    // R3: write 1 keeps, write 0 clears
    csr_wr(8'h80);
    ev_frame_err = 1; ev_parity_err = 1; tick();
    csr_wr(8'hFE);
    csr_wr(8'h80 | 8'h18);
    buf_rd = 0;
    bus_rd = 1; tick();
    chk("R3 write-1 keeps errors", {6'b0, bus_rdata[4:3]}, 8'h03);
    ev_frame_err = 1; tick();
    csr_wr(8'h80 | 8'h08);
    csr_rd();
    chk("R3 write-0 clears frame flag", {7'b0, bus_rdata[4]}, 8'h00);

    // R8: set and read-clear collide
    ev_frame_err = 1; bus_rd = 1; tick();
    csr_rd();
    chk("R8 set beats read clear", {7'b0, bus_rdata[4]}, 8'h01);
    csr_rd();
    chk("R2 read cleared frame flag", {7'b0, bus_rdata[4]}, 8'h00);

    // R4 / R6: rx flag then discard
    ev_rx_byte = 1; tick();
    csr_wr(8'h80);
    chk("R6 discard pulse", {7'b0, rx_discard}, 8'h01);
    tick();
    chk("R6 discard single cycle", {7'b0, rx_discard}, 8'h00);
    csr_wr(8'h80);
    chk("R6 no discard when clear", {7'b0, rx_discard}, 8'h00);

    // R4: SPI master ignores rx event
    csr_wr(8'h00);
    ev_rx_byte = 1; tick();
    csr_rd();
    chk("R4 master ignores rx", {7'b0, bus_rdata[2]}, 8'h00);
    // R5: SPI slave ignores tx event, R7 ss level
    csr_wr(8'h3E);
    ev_tx_byte = 1; tick();
    ss_level = 1; eng_busy = 0;
    csr_rd();
    chk("R5 slave ignores tx", {7'b0, bus_rdata[1]}, 8'h00);
    chk("R7 slave shows ss", {7'b0, bus_rdata[0]}, 8'h01);
    // R8 on tx: set with buffer-write clear in master mode
    csr_wr(8'h1E);
    ev_tx_byte = 1; buf_wr = 1; tick();
    csr_rd();
    chk("R8 tx set beats buffer write", {7'b0, bus_rdata[1]}, 8'h01);
    buf_wr = 1; tick();
    csr_rd();
    chk("R5 buffer write clears tx", {7'b0, bus_rdata[1]}, 8'h00);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bus_addr = ($urandom_range(0, 4) == 0) ? 8'($urandom()) : CSR;
      bus_wr = ($urandom_range(0, 9) < 2);
      bus_rd = ($urandom_range(0, 9) < 3);
      bus_wdata = 8'($urandom());
      buf_rd = ($urandom_range(0, 9) == 0);
      buf_wr = ($urandom_range(0, 9) == 0);
      ev_frame_err  = ($urandom_range(0, 5) == 0);
      ev_parity_err = ($urandom_range(0, 5) == 0);
      ev_rx_byte    = ($urandom_range(0, 3) == 0);
      ev_tx_byte    = ($urandom_range(0, 3) == 0);
      eng_busy = 1'($urandom());
      ss_level = 1'($urandom());
      if (i == 1500) rst = 1;
      if (i == 1502) rst = 0;
      tick();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule